// File: doc/BRIEF.md
# Indirect Register-Window Bus Bridge

This block lets software reach an internal bus with 32-bit addresses through four 64-bit registers: a command register, a placeholder reset register, a result register and a write-data register. Software loads the write-data register first when it has a store to make. It then writes one packed command word, which holds a direction flag, a byte count and a target address. The bridge runs exactly one transaction on the internal request/response port. When the port answers, the bridge records a completion flag in the result register, and for loads it also records the returned data.

The result register clears itself when it is read. A load that the bus rejects still reports completion, with all-ones in the data field. While a transaction is in flight, the bridge raises a busy output and drops any further command words. A command that asks for more than eight bytes is refused: no bus activity happens and the result register keeps its value.

Top module: `regwin_bridge`

## Requirements
- R1: The register is chosen by byte-address bits 4:3 (0 command, 1 reset, 2 result, 3 write data); all other address bits are ignored, so offset 0x38 reaches the write-data register.
- R2: A command write accepted while idle issues one bus request. Command bit 48 set means a load and clear means a store. Bits 59:56 give the byte count and bits 31:0 give the target address. The request stays raised, with stable fields, until the acknowledge arrives.
- R3: A command whose byte count is above 8 makes no bus request and leaves the result register unchanged.
- R4: A successful load sets the result to bit 11 (done) OR the 32-bit value shifted left by 26. The first returned byte, bus_rdata[63:56], is the most significant byte of that value.
- R5: A failed load sets the result to bit 11 OR 0xFFFFFFFF shifted left by 26.
- R6: A store drives the 32-bit write-data register onto byte lanes 0..3 (bus_wdata[63:32]), most significant byte first, with lanes 4..7 at zero. The result becomes bit 11 alone, whatever the success flag says.
- R7: Reading the result register returns its value and then clears it to zero. Writes to the result register are ignored. A completion in the same cycle as the read takes priority over the clear.
- R8: A write to the write-data register stores bits 63:32 of the word. A read returns the stored value in bits 63:32 with zeros below.
- R9: Reads of the command and reset registers return zero. Writes to the reset register change nothing.
- R10: busy is high from the cycle after an accepted command until the acknowledge. A command write made while busy is dropped.
- R11: Synchronous active-high reset clears the result register, the write-data register and busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| busy | output | 1 | Bus transaction in flight |
| bus_req | output | 1 | Internal bus request, held until acknowledge |
| bus_we | output | 1 | 1 = store, 0 = load |
| bus_addr | output | 32 | Internal bus byte address |
| bus_size | output | 4 | Byte count of the transaction |
| bus_wdata | output | 64 | Store data, lane 0 in bits 63:56 |
| bus_ack | input | 1 | Transaction complete (one cycle) |
| bus_ok | input | 1 | Transaction success flag, valid with bus_ack |
| bus_rdata | input | 64 | Load data, lane 0 in bits 63:56, valid with bus_ack |

## Verification
The hardest case to reach is a command word that arrives while an earlier transaction is still pending. With a fast responder, that window lasts only one or two cycles. The bench's memory model has a programmable response delay, so it can hold a request open for many cycles. During that time the bench writes a second command with a different address. It then checks that the model saw only one transaction and that it carried the first address. Oversized commands are checked against a result value that was set up on purpose, so that "unchanged" can be told apart from "cleared".

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    localparam int REG_W      = 64;
    localparam int BUS_AW     = 32;
    localparam int WIN_W      = 32;
    localparam int SIZE_W     = 4;
    localparam int LANES      = REG_W / 8;
    localparam int WIN_LANES  = WIN_W / 8;
    localparam int RD_FLAG    = 48;
    localparam int SIZE_LO    = 56;
    localparam int DONE_BIT   = 11;
    localparam int VAL_SHIFT  = 26;
    localparam int MAX_BYTES  = 8;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_RST  = 2'd1,
        SEL_RES  = 2'd2,
        SEL_WDAT = 2'd3
    } win_sel_e;

    typedef struct packed {
        logic              is_load;
        logic [SIZE_W-1:0] nbytes;
        logic [BUS_AW-1:0] addr;
    } win_cmd_t;

    typedef struct packed {
        logic             done;
        logic             was_load;
        logic             ok;
        logic [WIN_W-1:0] value;
    } win_result_t;

    function automatic win_cmd_t unpack_cmd(input logic [REG_W-1:0] w);
        win_cmd_t c;
        c.is_load = w[RD_FLAG];
        c.nbytes  = w[SIZE_LO +: SIZE_W];
        c.addr    = w[BUS_AW-1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] done_word();
        return REG_W'(1) << DONE_BIT;
    endfunction

    function automatic logic [REG_W-1:0] load_word(input logic [WIN_W-1:0] v);
        return (REG_W'(v) << VAL_SHIFT) | done_word();
    endfunction

    // Lane 0 sits in the top byte; the window occupies the first lanes.
    function automatic logic [WIN_W-1:0] lanes_to_value(input logic [REG_W-1:0] l);
        logic [WIN_W-1:0] v;
        for (int i = 0; i < WIN_LANES; i++)
            v[WIN_W-1-8*i -: 8] = l[REG_W-1-8*i -: 8];
        return v;
    endfunction

    function automatic logic [REG_W-1:0] value_to_lanes(input logic [WIN_W-1:0] v);
        logic [REG_W-1:0] l;
        l = '0;
        for (int i = 0; i < WIN_LANES; i++)
            l[REG_W-1-8*i -: 8] = v[WIN_W-1-8*i -: 8];
        return l;
    endfunction
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
    import regwin_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              busy,
    output win_sel_e          sel,
    output win_cmd_t          cmd,
    output logic              start,
    output logic              wdat_we,
    output logic              res_rd
);
    always_comb begin
        sel     = win_sel_e'(reg_addr[4:3]);
        cmd     = unpack_cmd(reg_wdata);
        start   = reg_wr && (sel == SEL_CMD) && !busy &&
                  (cmd.nbytes <= SIZE_W'(MAX_BYTES));
        wdat_we = reg_wr && (sel == SEL_WDAT);
        res_rd  = reg_rd && (sel == SEL_RES);
    end
endmodule

// File: rtl/regwin_bus_seq.sv
module regwin_bus_seq
    import regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  win_cmd_t          cmd,
    input  logic [WIN_W-1:0]  store_val,
    output logic              busy,
    output logic              bus_req,
    output logic              bus_we,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [SIZE_W-1:0] bus_size,
    output logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_ok,
    input  logic [REG_W-1:0]  bus_rdata,
    output win_result_t       result
);
    typedef enum logic { ST_IDLE, ST_WAIT } seq_e;

    seq_e             state_q;
    win_cmd_t         cmd_q;
    logic [WIN_W-1:0] store_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            store_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_WAIT;
                    cmd_q   <= cmd;
                    store_q <= store_val;
                end
                ST_WAIT: if (bus_ack) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q == ST_WAIT);
        bus_req   = busy;
        bus_we    = !cmd_q.is_load;
        bus_addr  = cmd_q.addr;
        bus_size  = cmd_q.nbytes;
        bus_wdata = value_to_lanes(store_q);
        result.done     = busy && bus_ack;
        result.was_load = cmd_q.is_load;
        result.ok       = bus_ok;
        result.value    = lanes_to_value(bus_rdata);
    end

    // R2: request and its fields hold until acknowledged
    a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));
    // R10: an acknowledge ends the transaction
    a_r10_ack_ends: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack) |=> !busy);
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
    import regwin_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              busy,
    output logic              bus_req,
    output logic              bus_we,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [SIZE_W-1:0] bus_size,
    output logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_ok,
    input  logic [REG_W-1:0]  bus_rdata
);
    win_sel_e         sel;
    win_cmd_t         cmd;
    logic             start, wdat_we, res_rd;
    win_result_t      result;
    logic [REG_W-1:0] res_q;
    logic [WIN_W-1:0] wdat_q;

    regwin_decode #(.ADDR_W(ADDR_W)) u_dec (
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_wdata(reg_wdata),
        .busy     (busy),
        .sel      (sel),
        .cmd      (cmd),
        .start    (start),
        .wdat_we  (wdat_we),
        .res_rd   (res_rd)
    );

    regwin_bus_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd      (cmd),
        .store_val(wdat_q),
        .busy     (busy),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_size (bus_size),
        .bus_wdata(bus_wdata),
        .bus_ack  (bus_ack),
        .bus_ok   (bus_ok),
        .bus_rdata(bus_rdata),
        .result   (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            wdat_q <= '0;
        end else begin
            if (wdat_we) wdat_q <= reg_wdata[REG_W-1 -: WIN_W];
            if (result.done) begin
                if (!result.was_load)  res_q <= done_word();
                else if (result.ok)    res_q <= load_word(result.value);
                else                   res_q <= load_word('1);
            end else if (res_rd) begin
                res_q <= '0;
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_RES:  reg_rdata = res_q;
            SEL_WDAT: reg_rdata = {wdat_q, {(REG_W-WIN_W){1'b0}}};
            default:  reg_rdata = '0;
        endcase
    end

    // R11: reset leaves result and write-data cleared
    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (res_q == '0 && wdat_q == '0 && !busy));
    // R7: a read of the result with no completion pending clears it
    a_r7_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (res_rd && !(bus_req && bus_ack)) |=> (res_q == '0));
    // R3: an oversized command issued while idle raises no request
    a_r3_no_oversize: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr[4:3] == 2'd0 && !busy &&
         reg_wdata[SIZE_LO +: SIZE_W] > SIZE_W'(MAX_BYTES)) |=> !bus_req);
    // R10: a command written while busy does not disturb the pending address
    a_r10_drop_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !bus_ack && reg_wr && reg_addr[4:3] == 2'd0) |=> $stable(bus_addr));
endmodule

// File: tb/sim_regwin_bridge.sv
module sim_regwin_bridge;
    logic        clk = 0;
    logic        rst = 1;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        busy, bus_req, bus_we;
    logic [31:0] bus_addr;
    logic [3:0]  bus_size;
    logic [63:0] bus_wdata;
    logic        bus_ack = 0, bus_ok = 0;
    logic [63:0] bus_rdata = '0;

    int checks = 0, fails = 0;
    int lat = 1;
    int txn_cnt = 0;
    logic        m_we;
    logic [31:0] m_addr;
    logic [3:0]  m_size;
    logic [63:0] m_wdata;

    localparam logic [7:0] A_CMD = 8'h00, A_RST = 8'h08, A_RES = 8'h10, A_WDAT = 8'h18;
    localparam logic [63:0] DONE = 64'h800;

    regwin_bridge u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_ok(bus_ok), .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;

    // Memory model: byte i of a load is addr[7:0]+i; addresses 0xF....... fail.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 0;
                cnt = 0;
            end else if (bus_req) begin
                if (cnt >= lat) begin
                    bus_ack = 1;
                    bus_ok  = (bus_addr[31:28] != 4'hF);
                    for (int i = 0; i < 8; i++)
                        bus_rdata[63-8*i -: 8] = bus_addr[7:0] + 8'(i);
                    m_we = bus_we; m_addr = bus_addr; m_size = bus_size; m_wdata = bus_wdata;
                    txn_cnt++;
                end else cnt++;
            end
        end
    end

    task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    function automatic logic [63:0] cmdw(input bit load, input logic [3:0] n, input logic [31:0] a);
        return (64'(load) << 48) | (64'(n) << 56) | 64'(a);
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic t_reset();
        logic [63:0] d;
        chk(!busy && !bus_req, "R11 busy after reset", 64'(busy), 0);
        rd(A_RES, d);  chk(d == 0, "R11 result after reset", d, 0);
        rd(A_WDAT, d); chk(d == 0, "R11 wdata after reset", d, 0);
    endtask

    task automatic t_wdat_and_decode();
        logic [63:0] d;
        wr(A_WDAT, 64'hA1B2C3D4_11223344);
        rd(A_WDAT, d); chk(d == 64'hA1B2C3D4_00000000, "R8 wdata readback", d, 64'hA1B2C3D4_00000000);
        rd(8'h38, d);  chk(d == 64'hA1B2C3D4_00000000, "R1 alias offset 0x38", d, 64'hA1B2C3D4_00000000);
        rd(A_CMD, d);  chk(d == 0, "R9 command reads zero", d, 0);
        wr(A_RST, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(A_RST, d);  chk(d == 0, "R9 reset reads zero", d, 0);
        rd(A_WDAT, d); chk(d == 64'hA1B2C3D4_00000000, "R9 reset write no effect", d, 64'hA1B2C3D4_00000000);
        chk(txn_cnt == 0 && !busy, "R9 reset write no bus op", 64'(txn_cnt), 0);
    endtask

    task automatic t_load_ok();
        logic [63:0] d, e;
        wr(A_CMD, cmdw(1, 4'd4, 32'h1234_5640));
        wait_idle();
        chk(m_addr == 32'h1234_5640 && !m_we && m_size == 4,
            "R2 load fields", {m_we, m_size, m_addr}, {1'b0, 4'd4, 32'h1234_5640});
        e = DONE | (64'h40414243 << 26);
        rd(A_RES, d); chk(d == e, "R4 load result", d, e);
        rd(A_RES, d); chk(d == 0, "R7 cleared after read", d, 0);
    endtask

    task automatic t_load_fail();
        logic [63:0] d, e;
        wr(A_CMD, cmdw(1, 4'd1, 32'hF000_0010));
        wait_idle();
        e = DONE | (64'hFFFFFFFF << 26);
        rd(A_RES, d); chk(d == e, "R5 failed load result", d, e);
    endtask

    task automatic t_store();
        logic [63:0] d;
        wr(A_CMD, cmdw(0, 4'd4, 32'h1000_0020));
        wait_idle();
        chk(m_we && m_addr == 32'h1000_0020, "R2 store fields", {m_we, m_addr}, {1'b1, 32'h1000_0020});
        chk(m_wdata == 64'hA1B2C3D4_00000000, "R6 store lanes", m_wdata, 64'hA1B2C3D4_00000000);
        rd(A_RES, d); chk(d == DONE, "R6 store result ok", d, DONE);
        wr(A_CMD, cmdw(0, 4'd2, 32'hF000_0000));
        wait_idle();
        rd(A_RES, d); chk(d == DONE, "R6 store result on failure", d, DONE);
    endtask

    task automatic t_oversize_and_resw();
        logic [63:0] d;
        int n0;
        wr(A_CMD, cmdw(0, 4'd8, 32'h0000_0004));
        wait_idle();
        n0 = txn_cnt;
        wr(A_CMD, cmdw(1, 4'd9, 32'h0000_0008));
        repeat (5) @(negedge clk);
        chk(txn_cnt == n0 && !busy, "R3 oversize no bus op", 64'(txn_cnt), 64'(n0));
        wr(A_RES, 64'h0);
        rd(A_RES, d); chk(d == DONE, "R3/R7 result kept, write ignored", d, DONE);
        rd(A_RES, d); chk(d == 0, "R7 clear after second read", d, 0);
    endtask

    task automatic t_busy_drop();
        logic [63:0] d, e;
        int n0;
        lat = 20;
        n0 = txn_cnt;
        wr(A_CMD, cmdw(1, 4'd4, 32'h0000_0080));
        chk(busy == 1, "R10 busy after command", 64'(busy), 1);
        wr(A_CMD, cmdw(1, 4'd4, 32'h0000_00C0));
        wait_idle();
        repeat (3) @(negedge clk);
        chk(txn_cnt == n0 + 1, "R10 one transaction only", 64'(txn_cnt), 64'(n0 + 1));
        chk(m_addr == 32'h80, "R10 first address used", 64'(m_addr), 64'h80);
        e = DONE | (64'h80818283 << 26);
        rd(A_RES, d); chk(d == e, "R10 result of first command", d, e);
        lat = 1;
    endtask

    task automatic t_mid_reset();
        logic [63:0] d;
        wr(A_WDAT, 64'h55AA55AA_00000000);
        wr(A_CMD, cmdw(0, 4'd4, 32'h100));
        wait_idle();
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        rd(A_WDAT, d); chk(d == 0, "R11 wdata cleared by reset", d, 0);
        rd(A_RES, d);  chk(d == 0, "R11 result cleared by reset", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_wdat_and_decode();
        t_load_ok();
        t_load_fail();
        t_store();
        t_oversize_and_resw();
        t_busy_drop();
        t_mid_reset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #200000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule